// File: doc/BRIEF.md
# Registered Command and Address Buffer with Parity Check

This block sits between a memory controller and a two-rank DRAM array. On every rising clock edge it captures the row/column address, bank address, the three command strobes and the per-rank select, clock-enable and termination-enable lines. It presents them to the DRAM devices from that edge until the next, so each word reaches the devices one cycle after the controller sends it. Every rank gets its own select, clock-enable and termination-enable output, taken from the input bit of the same index.

Alongside the bus the controller sends an even-parity bit. This bit covers the address lines and the three command strobes. The buffer checks it only in cycles that select at least one rank. A failed check drives an open-drain, active-low error line low for a fixed window. The window starts one cycle after the faulty word appears on the outputs. If the controller never drives the parity input, the error line misbehaves but the registered bus is unaffected.

An active-low reset clears every registered output at once, with no clock needed, which keeps clock enable low while power comes up. Reset release is synchronised internally, so the first word is captured on the third rising edge after release.

Top module: `cmdbuf_regbuf`

## Requirements
- R1: `addr_o`, `ba_o`, `ras_n_o`, `cas_n_o` and `we_n_o` take the values that the matching inputs held at the previous rising clock edge.
- R2: Each bit `cs_n_o[r]` is the registered copy of `cs_n_i[r]`, rank by rank, with the same one-cycle delay.
- R3: Each bit `cke_o[r]` and `odt_o[r]` is the registered copy of `cke_i[r]` and `odt_i[r]` for the same rank r.
- R4: While `rst_n` is low, every output, including `err_pull_o`, is 0. This takes effect as soon as `rst_n` falls, without waiting for a clock edge.
- R5: After `rst_n` rises, the outputs stay 0 across the next two rising edges. The third rising edge captures the inputs.
- R6: A word has a parity mismatch when the XOR of all `addr_i` bits, `ras_n_i`, `cas_n_i`, `we_n_i` and `par_i` is 1. `ba_i`, `cs_n_i`, `cke_i` and `odt_i` are not part of the check.
- R7: A word captured while every bit of `cs_n_i` is 1 never causes an error, whatever its parity.
- R8: A mismatched word with at least one rank selected sets `err_pull_o` to 1 from the edge after the one that puts the word on the outputs. It stays 1 for exactly two cycles and then returns to 0.
- R9: A second mismatch captured while the error window is open restarts the two-cycle window from its own timing.
- R10: A parity mismatch has no effect on the values passed to the registered outputs.
- R11: `err_pull_o` is the drive-low enable of the open-drain error line. A 1 pulls the line low and a 0 releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Buffer clock; everything is captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Address lines from the controller |
| ba_i | input | BANK_W | Bank address from the controller |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| cs_n_i | input | RANKS | Per-rank select, active low |
| cke_i | input | RANKS | Per-rank clock enable |
| odt_i | input | RANKS | Per-rank termination enable |
| par_i | input | 1 | Even-parity bit over address and command strobes |
| addr_o | output | ADDR_W | Registered address lines |
| ba_o | output | BANK_W | Registered bank address |
| ras_n_o | output | 1 | Registered row strobe |
| cas_n_o | output | 1 | Registered column strobe |
| we_n_o | output | 1 | Registered write strobe |
| cs_n_o | output | RANKS | Registered per-rank selects |
| cke_o | output | RANKS | Registered per-rank clock enables |
| odt_o | output | RANKS | Registered per-rank termination enables |
| err_pull_o | output | 1 | Drive-low enable of the open-drain parity error line |

## Verification
The bench aims at the parity corners:
- Words with odd parity that select no rank. A design that skipped the select qualification would raise false errors here.
- Words with an odd bank address but good parity. A design that folded the bank bits into the check would flag these.
- Back-to-back faulty words. A design without retriggering would drop the error line one cycle early.

The bench also samples the error line at the exact edges where it must rise and fall, which catches a window of the wrong length or offset. It pulls reset between clock edges to catch outputs that wait for a clock to clear. It watches the two edges after reset release, where a buffer with an unsynchronised release would start capturing too soon.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  // Per-rank control bundle carried through the buffer
  typedef struct packed {
    logic cs_n;
    logic cke;
    logic odt;
  } rank_ctl_t;

  // Command strobes; this group is covered by parity
  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;
endpackage

// File: rtl/cmdbuf_rst_sync.sv
module cmdbuf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/cmdbuf_bus_stage.sv
module cmdbuf_bus_stage
  import cmdbuf_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int RANKS  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr_d,
  input  logic [BANK_W-1:0]      ba_d,
  input  cmd_t                   cmd_d,
  input  rank_ctl_t [RANKS-1:0]  ctl_d,
  output logic [ADDR_W-1:0]      addr_q,
  output logic [BANK_W-1:0]      ba_q,
  output cmd_t                   cmd_q,
  output rank_ctl_t [RANKS-1:0]  ctl_q
);
  // Shared address/command register: loads every cycle
  logic shared_en;
  assign shared_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ba_q   <= '0;
      cmd_q  <= '0;
    end else if (shared_en) begin
      addr_q <= addr_d;
      ba_q   <= ba_d;
      cmd_q  <= cmd_d;
    end
  end

  // One register per rank for its select, clock enable and termination
  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    rank_ctl_t rank_q;
    logic      rank_en;
    assign rank_en = 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rank_q <= '0;
      else if (rank_en) rank_q <= ctl_d[r];
    end

    assign ctl_q[r] = rank_q;
  end
endmodule

// File: rtl/cmdbuf_parity.sv
module cmdbuf_parity
  import cmdbuf_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int RANKS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  cmd_t              cmd,
  input  logic [RANKS-1:0]  cs_n,
  input  logic              par,
  output logic              bad_q
);
  logic odd_word;
  logic any_sel;
  logic bad_d;

  always_comb begin
    odd_word = ^{addr, cmd, par};
    any_sel  = ~(&cs_n);
    bad_d    = odd_word & any_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= bad_d;
  end
endmodule

// File: rtl/cmdbuf_err_hold.sv
module cmdbuf_err_hold #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pull_o
);
  localparam int CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = trig | (cnt_q != '0);
    cnt_d  = trig ? CNT_W'(HOLD) : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pull_o = (cnt_q != '0);
endmodule

// File: rtl/cmdbuf_regbuf.sv
module cmdbuf_regbuf
  import cmdbuf_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int BANK_W   = 3,
  parameter int RANKS    = 2,
  parameter int ERR_HOLD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [RANKS-1:0]  cs_n_i,
  input  logic [RANKS-1:0]  cke_i,
  input  logic [RANKS-1:0]  odt_i,
  input  logic              par_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] ba_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [RANKS-1:0]  cs_n_o,
  output logic [RANKS-1:0]  cke_o,
  output logic [RANKS-1:0]  odt_o,
  output logic              err_pull_o
);
  logic                  core_rst_n;
  cmd_t                  cmd_in;
  cmd_t                  cmd_out;
  rank_ctl_t [RANKS-1:0] ctl_in;
  rank_ctl_t [RANKS-1:0] ctl_out;
  logic                  bad_word;

  cmdbuf_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  assign cmd_in = '{ras_n: ras_n_i, cas_n: cas_n_i, we_n: we_n_i};

  for (genvar r = 0; r < RANKS; r++) begin : g_map
    assign ctl_in[r] = '{cs_n: cs_n_i[r], cke: cke_i[r], odt: odt_i[r]};
    assign cs_n_o[r] = ctl_out[r].cs_n;
    assign cke_o[r]  = ctl_out[r].cke;
    assign odt_o[r]  = ctl_out[r].odt;
  end

  cmdbuf_bus_stage #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .RANKS(RANKS)) u_bus (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .addr_d (addr_i),
    .ba_d   (ba_i),
    .cmd_d  (cmd_in),
    .ctl_d  (ctl_in),
    .addr_q (addr_o),
    .ba_q   (ba_o),
    .cmd_q  (cmd_out),
    .ctl_q  (ctl_out)
  );

  assign ras_n_o = cmd_out.ras_n;
  assign cas_n_o = cmd_out.cas_n;
  assign we_n_o  = cmd_out.we_n;

  cmdbuf_parity #(.ADDR_W(ADDR_W), .RANKS(RANKS)) u_par (
    .clk   (clk),
    .rst_n (core_rst_n),
    .addr  (addr_i),
    .cmd   (cmd_in),
    .cs_n  (cs_n_i),
    .par   (par_i),
    .bad_q (bad_word)
  );

  cmdbuf_err_hold #(.HOLD(ERR_HOLD)) u_err (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .trig   (bad_word),
    .pull_o (err_pull_o)
  );
endmodule

// File: rtl/cmdbuf_regbuf_chk.sv
module cmdbuf_regbuf_chk #(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int RANKS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BANK_W-1:0] ba_i,
  input logic              ras_n_i,
  input logic              cas_n_i,
  input logic              we_n_i,
  input logic [RANKS-1:0]  cs_n_i,
  input logic [RANKS-1:0]  cke_i,
  input logic [RANKS-1:0]  odt_i,
  input logic              par_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BANK_W-1:0] ba_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [RANKS-1:0]  cs_n_o,
  input logic [RANKS-1:0]  cke_o,
  input logic [RANKS-1:0]  odt_o,
  input logic              err_pull_o
);
  logic sel_bad;
  logic outs_zero;

  assign sel_bad   = (^{addr_i, ras_n_i, cas_n_i, we_n_i, par_i}) & ~(&cs_n_i);
  assign outs_zero = ({addr_o, ba_o, ras_n_o, cas_n_o, we_n_o, cs_n_o, cke_o, odt_o,
                       err_pull_o} == '0);

  assert_bus_latency_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    $past(core_rst_n) |-> ({addr_o, ba_o, ras_n_o, cas_n_o, we_n_o} ==
                           $past({addr_i, ba_i, ras_n_i, cas_n_i, we_n_i})));

  assert_rank_select_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    $past(core_rst_n) |-> (cs_n_o == $past(cs_n_i)));

  assert_rank_ctl_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    $past(core_rst_n) |-> ({cke_o, odt_o} == $past({cke_i, odt_i})));

  assert_reset_clears_R4: assert property (@(posedge clk)
    !rst_n |-> outs_zero);

  assert_release_hold_R5: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |=> outs_zero);

  assert_err_origin_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(err_pull_o) |-> $past(sel_bad, 2));

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!$past(sel_bad, 2) && !$past(sel_bad, 3)) |-> !err_pull_o);

  assert_err_set_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($past(core_rst_n, 2) && $past(sel_bad, 2)) |-> err_pull_o);

  assert_err_keep_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($past(core_rst_n, 3) && $past(sel_bad, 3)) |-> err_pull_o);
endmodule

bind cmdbuf_regbuf cmdbuf_regbuf_chk #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W),
  .RANKS  (RANKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .addr_i     (addr_i),
  .ba_i       (ba_i),
  .ras_n_i    (ras_n_i),
  .cas_n_i    (cas_n_i),
  .we_n_i     (we_n_i),
  .cs_n_i     (cs_n_i),
  .cke_i      (cke_i),
  .odt_i      (odt_i),
  .par_i      (par_i),
  .addr_o     (addr_o),
  .ba_o       (ba_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .we_n_o     (we_n_o),
  .cs_n_o     (cs_n_o),
  .cke_o      (cke_o),
  .odt_o      (odt_o),
  .err_pull_o (err_pull_o)
);

// File: tb/cmdbuf_regbuf_test.sv
module cmdbuf_regbuf_test;
  localparam int ADDR_W = 14;
  localparam int BANK_W = 3;
  localparam int RANKS  = 2;

  typedef struct packed {
    logic [13:0] addr;
    logic [2:0]  ba;
    logic        ras_n;
    logic        cas_n;
    logic        we_n;
    logic [1:0]  cs_n;
    logic [1:0]  cke;
    logic [1:0]  odt;
    logic        par;
    logic        bad;   // expected: selected word with odd parity
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{14'h0000, 3'd0, 1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 2'b00, 1'b1, 1'b0},
    '{14'h0001, 3'd2, 1'b0, 1'b1, 1'b1, 2'b10, 2'b01, 2'b10, 1'b1, 1'b0},
    '{14'h0001, 3'd5, 1'b0, 1'b1, 1'b1, 2'b10, 2'b11, 2'b01, 1'b0, 1'b1},
    '{14'h0003, 3'd1, 1'b1, 1'b0, 1'b1, 2'b01, 2'b10, 2'b11, 1'b0, 1'b0},
    '{14'h3FFF, 3'd7, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, 2'b00, 1'b0, 1'b0},
    '{14'h2AAA, 3'd3, 1'b1, 1'b1, 1'b0, 2'b11, 2'b01, 2'b01, 1'b0, 1'b0},
    '{14'h2AAA, 3'd4, 1'b1, 1'b1, 1'b0, 2'b01, 2'b10, 2'b10, 1'b0, 1'b1},
    '{14'h0000, 3'd6, 1'b1, 1'b1, 1'b1, 2'b00, 2'b11, 2'b11, 1'b1, 1'b0},
    '{14'h1000, 3'd0, 1'b1, 1'b1, 1'b1, 2'b10, 2'b00, 2'b01, 1'b0, 1'b0},
    '{14'h1000, 3'd1, 1'b1, 1'b1, 1'b1, 2'b11, 2'b01, 2'b00, 1'b1, 1'b0},
    '{14'h0000, 3'd0, 1'b1, 1'b1, 1'b1, 2'b11, 2'b11, 2'b00, 1'b1, 1'b0},
    '{14'h0000, 3'd0, 1'b1, 1'b1, 1'b1, 2'b11, 2'b11, 2'b00, 1'b1, 1'b0}
  };

  localparam vec_t BAD_VEC  = '{14'h0001, 3'd0, 1'b0, 1'b1, 1'b1, 2'b10, 2'b11, 2'b00, 1'b0, 1'b1};
  localparam vec_t IDLE_VEC = '{14'h0000, 3'd0, 1'b1, 1'b1, 1'b1, 2'b11, 2'b11, 2'b00, 1'b1, 1'b0};

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] addr_i;
  logic [BANK_W-1:0] ba_i;
  logic              ras_n_i, cas_n_i, we_n_i;
  logic [RANKS-1:0]  cs_n_i, cke_i, odt_i;
  logic              par_i;
  logic [ADDR_W-1:0] addr_o;
  logic [BANK_W-1:0] ba_o;
  logic              ras_n_o, cas_n_o, we_n_o;
  logic [RANKS-1:0]  cs_n_o, cke_o, odt_o;
  logic              err_pull_o;

  int n_checks;
  int n_fail;

  cmdbuf_regbuf #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .RANKS(RANKS)) uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ba_i(ba_i),
    .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
    .cs_n_i(cs_n_i), .cke_i(cke_i), .odt_i(odt_i), .par_i(par_i),
    .addr_o(addr_o), .ba_o(ba_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .cs_n_o(cs_n_o), .cke_o(cke_o), .odt_o(odt_o),
    .err_pull_o(err_pull_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    addr_i  = v.addr;
    ba_i    = v.ba;
    ras_n_i = v.ras_n;
    cas_n_i = v.cas_n;
    we_n_i  = v.we_n;
    cs_n_i  = v.cs_n;
    cke_i   = v.cke;
    odt_i   = v.odt;
    par_i   = v.par;
  endtask

  function automatic logic [31:0] core_out();
    return 32'({addr_o, ba_o, ras_n_o, cas_n_o, we_n_o});
  endfunction

  function automatic logic [31:0] all_out();
    return 32'({addr_o, ba_o, ras_n_o, cas_n_o, we_n_o, cs_n_o, cke_o, odt_o, err_pull_o});
  endfunction

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic bad_m1, bad_m2;
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    drive(IDLE_VEC);
    repeat (2) @(negedge clk);
    chk("R4 reset state", all_out(), 32'd0);

    // R5: release with non-zero inputs; two edges must pass before capture
    drive('{14'h3FFF, 3'd7, 1'b0, 1'b0, 1'b0, 2'b11, 2'b11, 2'b11, 1'b1, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 first edge after release", all_out(), 32'd0);
    @(negedge clk);
    chk("R5 second edge after release", all_out(), 32'd0);
    @(negedge clk);
    chk("R5 third edge captures", core_out(), 32'({14'h3FFF, 3'd7, 3'b000}));

    // Table walk
    bad_m1 = 1'b0;
    bad_m2 = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      chk("R1 R10 address and command", core_out(),
          32'({VECS[i].addr, VECS[i].ba, VECS[i].ras_n, VECS[i].cas_n, VECS[i].we_n}));
      chk("R2 rank selects", 32'(cs_n_o), 32'(VECS[i].cs_n));
      chk("R3 rank cke and odt", 32'({cke_o, odt_o}), 32'({VECS[i].cke, VECS[i].odt}));
      chk("R6 R7 R8 R11 error enable", 32'(err_pull_o), 32'(bad_m1 | bad_m2));
      bad_m2 = bad_m1;
      bad_m1 = VECS[i].bad;
    end

    // R9: two faulty words back to back stretch the window to three cycles
    drive(BAD_VEC);
    @(negedge clk);
    chk("R9 first bad captured, no error yet", 32'(err_pull_o), 32'd0);
    @(negedge clk);
    chk("R9 error rises", 32'(err_pull_o), 32'd1);
    drive(IDLE_VEC);
    @(negedge clk);
    chk("R9 error held", 32'(err_pull_o), 32'd1);
    @(negedge clk);
    chk("R9 retriggered window", 32'(err_pull_o), 32'd1);
    @(negedge clk);
    chk("R9 window closes", 32'(err_pull_o), 32'd0);

    // R4: reset pulled between edges while the error line is active
    drive(BAD_VEC);
    @(negedge clk);
    drive('{14'h1234, 3'd5, 1'b0, 1'b0, 1'b1, 2'b00, 2'b11, 2'b11, 1'b0, 1'b0});
    @(negedge clk);
    chk("R8 error active before reset", 32'(err_pull_o), 32'd1);
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R4 asynchronous clear", all_out(), 32'd0);
    @(negedge clk);
    chk("R4 held during reset", all_out(), 32'd0);
    drive(IDLE_VEC);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 R5 recovered bus", core_out(), 32'({14'h0000, 3'd0, 3'b111}));
    chk("R8 no error after reset", 32'(err_pull_o), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule